// File: doc/BRIEF.md
# Video Controller Register Front End with Warm-Up Gating

This block is the processor-facing register file of a tile-based video controller. It decodes 8-bit processor accesses at eight register offsets. It holds the control byte, the mask byte, the temporary and current video-memory addresses, the fine horizontal scroll, the shared first/second-write toggle, the data-port read buffer, the object-memory address and the vertical-blank flag. The surrounding pixel pipeline, memories and frame timing counter are outside the block. They reach it as three inputs: a memory read-data bus, a vblank-start strobe and a vblank-end strobe.

Power-on and soft reset both start an internal warm-up state. During warm-up the block ignores writes to the control, mask, scroll and address offsets, so the toggle does not flip. Object-memory accesses, data-port accesses and status reads still take effect. Warm-up ends on the first vblank-end strobe. In the intended system that strobe arrives some tens of thousands of processor clocks after reset. Soft reset leaves the current video address, the object-memory address and the vblank flag as they were.

Top module: `vreg_front`

## Requirements
- R1: After power-on reset every held value is zero: control, mask, temporary address, current address, fine scroll, toggle, read buffer, object-memory address and vblank flag. Warm-up is active.
- R2: A soft reset pulse has the following effects. It clears control, mask, temporary address, fine scroll, toggle and read buffer. It sets warm-up. It leaves the current address, the object-memory address and the vblank flag unchanged. It overrides any access or strobe in the same cycle.
- R3: Warm-up stays active until a vblank-end strobe arrives with no soft reset in the same cycle. A vblank-end strobe also clears the vblank flag.
- R4: While warm-up is active, writes to offset 0 (control), 1 (mask), 5 (scroll) and 6 (address) change no register, and the toggle keeps its value.
- R5: Writes to offsets 3, 4 and 7 act at all times, including during warm-up. Offset 3 loads the object-memory address. Offset 4 increments the object-memory address by 1. Offset 7 advances the current address.
- R6: A read at offset 2 returns the vblank flag in bit 7, with bits 6..0 zero. On the next cycle the vblank flag and the toggle are clear. A vblank-start strobe sets the flag and wins over a clear in the same cycle.
- R7: Scroll writes (offset 5) behave as follows. With the toggle at 0, the write places data bits 7..3 into temporary bits 4..0 and data bits 2..0 into the fine scroll. With the toggle at 1, it places data bits 7..3 into temporary bits 9..5 and data bits 2..0 into temporary bits 14..12. Each write flips the toggle.
- R8: Address writes (offset 6) behave as follows. With the toggle at 0, the write places data bits 5..0 into temporary bits 13..8 and clears bit 14. With the toggle at 1, it places the data byte into temporary bits 7..0 and copies the whole new temporary address into the current address. Each write flips the toggle.
- R9: A control write (offset 0) loads the control byte and copies data bits 1..0 into temporary bits 11..10. A mask write (offset 1) loads the mask byte.
- R10: A data read (offset 7) returns the buffer contents held before the access. It then loads the buffer from the memory read-data input. The current address advances by 32 when control bit 2 is set and by 1 otherwise, modulo 2^15. Reads at other offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset pulse, synchronous, active high |
| vblank_start | input | 1 | Frame timing strobe that sets the vblank flag |
| vblank_end | input | 1 | Frame timing strobe that ends vblank and warm-up |
| cs | input | 1 | Register access select, one cycle per access |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| mem_rdata | input | 8 | Video memory read data for the buffer refill |
| rdata | output | 8 | Read data, combinational during a read |
| ctrl_o | output | 8 | Control byte |
| mask_o | output | 8 | Mask byte |
| t_addr_o | output | 15 | Temporary video address |
| v_addr_o | output | 15 | Current video address |
| fine_x_o | output | 3 | Fine horizontal scroll |
| toggle_o | output | 1 | First/second write toggle |
| rbuf_o | output | 8 | Data-port read buffer |
| oam_addr_o | output | 8 | Object-memory address |
| vblank_o | output | 1 | Vblank flag |
| warm_o | output | 1 | Warm-up (internal reset) active |

## Verification
The assertions assume one access per select cycle, with a fully driven offset. They assume vblank-start and vblank-end are never asserted together, and that soft reset is a synchronous pulse that can coincide with any other input. The bench drives each access for exactly one clock between falling edges. It pulses each strobe alone, except in the one deliberate case where soft reset and vblank-end land in the same cycle to exercise reset priority.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned VADDR_W = 15;
    localparam int unsigned FINE_W  = 3;
    localparam int unsigned OFS_W   = 3;

    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL = 3'd0,
        OFS_MASK = 3'd1,
        OFS_STAT = 3'd2,
        OFS_OADR = 3'd3,
        OFS_ODAT = 3'd4,
        OFS_SCRL = 3'd5,
        OFS_ADDR = 3'd6,
        OFS_DATA = 3'd7
    } reg_ofs_e;

    typedef struct packed {
        logic ctrl_wr;
        logic mask_wr;
        logic stat_rd;
        logic oadr_wr;
        logic odat_wr;
        logic scrl_wr;
        logic addr_wr;
        logic data_rd;
        logic data_wr;
    } acc_s;

    typedef struct packed {
        logic [VADDR_W-1:0] t;
        logic [VADDR_W-1:0] v;
        logic [FINE_W-1:0]  fx;
        logic               tog;
    } scroll_s;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] oam;
        logic [DATA_W-1:0] rbuf;
        logic              vblank;
    } core_s;
endpackage

// File: rtl/vreg_decode.sv
module vreg_decode
    import vreg_pkg::*;
(
    input  logic             cs,
    input  logic             rw,
    input  logic [OFS_W-1:0] addr,
    input  logic             warm,
    input  logic             soft_rst,
    output acc_s             acc
);
    logic live;
    logic wr_ok;
    logic wr_gated_ok;

    always_comb begin
        live        = cs && !soft_rst;
        wr_ok       = live && !rw;
        wr_gated_ok = wr_ok && !warm;
        acc         = '0;
        unique case (reg_ofs_e'(addr))
            OFS_CTRL: acc.ctrl_wr = wr_gated_ok;
            OFS_MASK: acc.mask_wr = wr_gated_ok;
            OFS_STAT: acc.stat_rd = live && rw;
            OFS_OADR: acc.oadr_wr = wr_ok;
            OFS_ODAT: acc.odat_wr = wr_ok;
            OFS_SCRL: acc.scrl_wr = wr_gated_ok;
            OFS_ADDR: acc.addr_wr = wr_gated_ok;
            OFS_DATA: begin
                acc.data_rd = live && rw;
                acc.data_wr = wr_ok;
            end
            default: acc = '0;
        endcase
    end
endmodule

// File: rtl/vreg_warm.sv
module vreg_warm (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic vblank_end,
    output logic warm
);
    logic warm_d, warm_q;

    always_comb begin
        warm_d = warm_q;
        if (soft_rst)        warm_d = 1'b1;
        else if (vblank_end) warm_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b1;
        else        warm_q <= warm_d;
    end

    assign warm = warm_q;
endmodule

// File: rtl/vreg_scroll.sv
module vreg_scroll
    import vreg_pkg::*;
#(
    parameter int unsigned ROW_STEP = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  acc_s               acc,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               step_row,
    output logic [VADDR_W-1:0] t_addr,
    output logic [VADDR_W-1:0] v_addr,
    output logic [FINE_W-1:0]  fine_x,
    output logic               toggle
);
    localparam logic [VADDR_W-1:0] STEP_ROW = VADDR_W'(ROW_STEP);
    localparam logic [VADDR_W-1:0] STEP_COL = VADDR_W'(1);

    scroll_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (soft_rst) begin
            s_d.t   = '0;
            s_d.fx  = '0;
            s_d.tog = 1'b0;
        end else begin
            if (acc.ctrl_wr) s_d.t[11:10] = wdata[1:0];
            if (acc.scrl_wr) begin
                if (!s_q.tog) begin
                    s_d.t[4:0] = wdata[7:3];
                    s_d.fx     = wdata[2:0];
                end else begin
                    s_d.t[9:5]   = wdata[7:3];
                    s_d.t[14:12] = wdata[2:0];
                end
                s_d.tog = !s_q.tog;
            end
            if (acc.addr_wr) begin
                if (!s_q.tog) begin
                    s_d.t[14]   = 1'b0;
                    s_d.t[13:8] = wdata[5:0];
                end else begin
                    s_d.t[7:0] = wdata;
                    s_d.v      = s_d.t;
                end
                s_d.tog = !s_q.tog;
            end
            if (acc.data_rd || acc.data_wr)
                s_d.v = s_q.v + (step_row ? STEP_ROW : STEP_COL);
            if (acc.stat_rd) s_d.tog = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign t_addr = s_q.t;
    assign v_addr = s_q.v;
    assign fine_x = s_q.fx;
    assign toggle = s_q.tog;
endmodule

// File: rtl/vreg_front.sv
module vreg_front
    import vreg_pkg::*;
#(
    parameter int unsigned ROW_STEP = 32,
    parameter int unsigned STEP_BIT = 2
) (
    input  logic               clk,
    input  logic               rst_por_n,
    input  logic               soft_rst,
    input  logic               vblank_start,
    input  logic               vblank_end,
    input  logic               cs,
    input  logic               rw,
    input  logic [OFS_W-1:0]   addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [DATA_W-1:0]  ctrl_o,
    output logic [DATA_W-1:0]  mask_o,
    output logic [VADDR_W-1:0] t_addr_o,
    output logic [VADDR_W-1:0] v_addr_o,
    output logic [FINE_W-1:0]  fine_x_o,
    output logic               toggle_o,
    output logic [DATA_W-1:0]  rbuf_o,
    output logic [DATA_W-1:0]  oam_addr_o,
    output logic               vblank_o,
    output logic               warm_o
);
    acc_s  acc;
    logic  warm;
    core_s c_d, c_q;

    vreg_warm u_warm (
        .clk        (clk),
        .rst_n      (rst_por_n),
        .soft_rst   (soft_rst),
        .vblank_end (vblank_end),
        .warm       (warm)
    );

    vreg_decode u_dec (
        .cs       (cs),
        .rw       (rw),
        .addr     (addr),
        .warm     (warm),
        .soft_rst (soft_rst),
        .acc      (acc)
    );

    vreg_scroll #(.ROW_STEP(ROW_STEP)) u_scr (
        .clk      (clk),
        .rst_n    (rst_por_n),
        .soft_rst (soft_rst),
        .acc      (acc),
        .wdata    (wdata),
        .step_row (c_q.ctrl[STEP_BIT]),
        .t_addr   (t_addr_o),
        .v_addr   (v_addr_o),
        .fine_x   (fine_x_o),
        .toggle   (toggle_o)
    );

    always_comb begin
        c_d = c_q;
        if (soft_rst) begin
            c_d.ctrl = '0;
            c_d.mask = '0;
            c_d.rbuf = '0;
        end else begin
            if (acc.ctrl_wr) c_d.ctrl = wdata;
            if (acc.mask_wr) c_d.mask = wdata;
            if (acc.oadr_wr) c_d.oam  = wdata;
            if (acc.odat_wr) c_d.oam  = c_q.oam + DATA_W'(1);
            if (acc.data_rd) c_d.rbuf = mem_rdata;
            if (vblank_start)                 c_d.vblank = 1'b1;
            else if (vblank_end || acc.stat_rd) c_d.vblank = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n) c_q <= '0;
        else            c_q <= c_d;
    end

    always_comb begin
        rdata = '0;
        if (cs && rw) begin
            case (reg_ofs_e'(addr))
                OFS_STAT: rdata = {c_q.vblank, {(DATA_W-1){1'b0}}};
                OFS_DATA: rdata = c_q.rbuf;
                default:  rdata = '0;
            endcase
        end
    end

    assign ctrl_o     = c_q.ctrl;
    assign mask_o     = c_q.mask;
    assign rbuf_o     = c_q.rbuf;
    assign oam_addr_o = c_q.oam;
    assign vblank_o   = c_q.vblank;
    assign warm_o     = warm;
endmodule

// File: rtl/vreg_front_chk.sv
module vreg_front_chk (
    input logic        clk,
    input logic        rst_por_n,
    input logic        soft_rst,
    input logic        vblank_start,
    input logic        vblank_end,
    input logic        cs,
    input logic        rw,
    input logic [2:0]  addr,
    input logic [7:0]  ctrl_o,
    input logic [7:0]  mask_o,
    input logic        toggle_o,
    input logic [14:0] v_addr_o,
    input logic [7:0]  oam_addr_o,
    input logic        vblank_o,
    input logic        warm_o
);
    assert_soft_sets_warm_R2: assert property (@(posedge clk) disable iff (!rst_por_n)
        soft_rst |=> warm_o);

    assert_soft_keeps_state_R2: assert property (@(posedge clk) disable iff (!rst_por_n)
        soft_rst |=> ($stable(v_addr_o) && $stable(oam_addr_o) && $stable(vblank_o)));

    assert_warm_release_R3: assert property (@(posedge clk) disable iff (!rst_por_n)
        (vblank_end && !soft_rst) |=> !warm_o);

    assert_warm_holds_R3: assert property (@(posedge clk) disable iff (!rst_por_n)
        (warm_o && !vblank_end) |=> warm_o);

    assert_gated_regs_zero_R4: assert property (@(posedge clk) disable iff (!rst_por_n)
        warm_o |-> (ctrl_o == 8'h00 && mask_o == 8'h00 && !toggle_o));

    assert_status_clears_R6: assert property (@(posedge clk) disable iff (!rst_por_n)
        (cs && rw && addr == 3'd2 && !soft_rst && !vblank_start) |=> (!vblank_o && !toggle_o));

    assert_vblank_set_R6: assert property (@(posedge clk) disable iff (!rst_por_n)
        (vblank_start && !soft_rst) |=> vblank_o);
endmodule

bind vreg_front vreg_front_chk u_chk (.*);

// File: tb/vreg_front_bench.sv
module vreg_front_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_por_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        vblank_start = 1'b0;
    logic        vblank_end = 1'b0;
    logic        cs = 1'b0;
    logic        rw = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  ctrl_o, mask_o, rbuf_o, oam_addr_o;
    logic [14:0] t_addr_o, v_addr_o;
    logic [2:0]  fine_x_o;
    logic        toggle_o, vblank_o, warm_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vreg_front u_vreg_front (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rw = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rw = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rw = 1'b0;
    endtask

    task automatic pulse_vs();
        @(negedge clk); vblank_start = 1'b1;
        @(negedge clk); vblank_start = 1'b0;
    endtask

    task automatic pulse_ve();
        @(negedge clk); vblank_end = 1'b1;
        @(negedge clk); vblank_end = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [14:0] mv;
        logic [7:0]  mbuf;
        repeat (3) @(negedge clk);
        rst_por_n = 1'b1;
        @(negedge clk);

        // R1 power-on values
        chk("R1 ctrl", ctrl_o, 0);
        chk("R1 mask", mask_o, 0);
        chk("R1 t", t_addr_o, 0);
        chk("R1 v", v_addr_o, 0);
        chk("R1 fx", fine_x_o, 0);
        chk("R1 toggle", toggle_o, 0);
        chk("R1 rbuf", rbuf_o, 0);
        chk("R1 oam", oam_addr_o, 0);
        chk("R1 vblank", vblank_o, 0);
        chk("R1 warm", warm_o, 1);

        // R4 gated writes during warm-up, sweep of offsets and data
        for (int d = 1; d < 256; d += 23) begin
            wr(3'd0, 8'(d)); wr(3'd1, 8'(d)); wr(3'd5, 8'(d)); wr(3'd6, 8'(d));
            chk("R4 ctrl", ctrl_o, 0);
            chk("R4 mask", mask_o, 0);
            chk("R4 t", t_addr_o, 0);
            chk("R4 fx", fine_x_o, 0);
            chk("R4 toggle", toggle_o, 0);
            chk("R4 v", v_addr_o, 0);
        end

        // R5 ungated offsets during warm-up
        wr(3'd3, 8'h40);
        chk("R5 oam load", oam_addr_o, 8'h40);
        wr(3'd4, 8'h99); wr(3'd4, 8'h11);
        chk("R5 oam incr", oam_addr_o, 8'h42);
        wr(3'd3, 8'hFF); wr(3'd4, 8'h00);
        chk("R5 oam wrap", oam_addr_o, 8'h00);
        wr(3'd7, 8'h55);
        chk("R5 data write advances v", v_addr_o, 15'd1);
        chk("R5 still warm", warm_o, 1);

        // R6 status read during warm-up
        pulse_vs();
        chk("R6 vblank set", vblank_o, 1);
        rd(3'd2, r);
        chk("R6 status data", r, 8'h80);
        chk("R6 vblank cleared", vblank_o, 0);
        rd(3'd2, r);
        chk("R6 status data clear", r, 8'h00);
        chk("R3 warm held", warm_o, 1);

        // R3 release by vblank-end; vblank also cleared
        pulse_vs();
        pulse_ve();
        chk("R3 warm released", warm_o, 0);
        chk("R3 vblank cleared by end", vblank_o, 0);

        // R9 control and mask sweep
        for (int d = 0; d < 256; d += 17) begin
            wr(3'd0, 8'(d));
            chk("R9 ctrl", ctrl_o, 32'(d));
            chk("R9 t[11:10]", 32'(t_addr_o[11:10]), 32'(d & 3));
            wr(3'd1, 8'(255 - d));
            chk("R9 mask", mask_o, 32'(255 - d));
        end

        // R7 scroll pairs after a control write
        for (int x = 0; x < 256; x += 29) begin
            for (int y = 7; y < 256; y += 41) begin
                wr(3'd0, 8'(x ^ y) & 8'h03);
                wr(3'd5, 8'(x));
                chk("R7 toggle after first", toggle_o, 1);
                wr(3'd5, 8'(y));
                chk("R7 toggle after second", toggle_o, 0);
                chk("R7 t", t_addr_o,
                    32'(((y & 7) << 12) | (((x ^ y) & 3) << 10) | ((y >> 3) << 5) | (x >> 3)));
                chk("R7 fx", fine_x_o, 32'(x & 7));
            end
        end

        // R8 address pairs
        for (int h = 0; h < 256; h += 37) begin
            for (int l = 3; l < 256; l += 61) begin
                wr(3'd6, 8'(h));
                chk("R8 t high", 32'(t_addr_o[14:8]), 32'(h & 8'h3F));
                wr(3'd6, 8'(l));
                chk("R8 v copy", v_addr_o, 32'(((h & 8'h3F) << 8) | l));
            end
        end

        // R6 status read resets the toggle mid pair
        wr(3'd6, 8'h21);
        rd(3'd2, r);
        chk("R6 toggle cleared", toggle_o, 0);
        wr(3'd6, 8'h12); wr(3'd6, 8'h34);
        chk("R6 restarted pair", v_addr_o, 15'h1234);

        // R10 data reads, step 1 then step 32
        wr(3'd0, 8'h00);
        mv = 15'h1234; mbuf = 8'h00;
        for (int k = 0; k < 6; k++) begin
            if (k == 3) wr(3'd0, 8'h04);
            mem_rdata = 8'(8'hA0 + k);
            rd(3'd7, r);
            chk("R10 read returns old buffer", r, mbuf);
            mbuf = 8'(8'hA0 + k);
            mv = mv + ((k >= 3) ? 15'd32 : 15'd1);
            chk("R10 buffer refilled", rbuf_o, mbuf);
            chk("R10 v step", v_addr_o, mv);
        end
        wr(3'd6, 8'h3F); wr(3'd6, 8'hF0);
        for (int k = 0; k < 3; k++) rd(3'd7, r);
        chk("R10 v large", v_addr_o, 15'h4050);
        rd(3'd3, r);
        chk("R10 other offset reads zero", r, 0);

        // R2 soft reset
        wr(3'd3, 8'h77);
        wr(3'd1, 8'h3C);
        wr(3'd5, 8'hFF);
        pulse_vs();
        mv = v_addr_o;
        pulse_soft();
        chk("R2 ctrl", ctrl_o, 0);
        chk("R2 mask", mask_o, 0);
        chk("R2 t", t_addr_o, 0);
        chk("R2 fx", fine_x_o, 0);
        chk("R2 toggle", toggle_o, 0);
        chk("R2 rbuf", rbuf_o, 0);
        chk("R2 warm", warm_o, 1);
        chk("R2 v kept", v_addr_o, mv);
        chk("R2 oam kept", oam_addr_o, 8'h77);
        chk("R2 vblank kept", vblank_o, 1);
        wr(3'd0, 8'h81);
        chk("R4 ctrl ignored after soft", ctrl_o, 0);

        // R3 soft reset beats a same-cycle vblank-end
        @(negedge clk); soft_rst = 1'b1; vblank_end = 1'b1;
        @(negedge clk); soft_rst = 1'b0; vblank_end = 1'b0;
        chk("R3 warm kept on coincident reset", warm_o, 1);
        pulse_ve();
        chk("R3 warm released after soft", warm_o, 0);
        wr(3'd0, 8'h81);
        chk("R9 ctrl after release", ctrl_o, 8'h81);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule